// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

The block produces three pairs of active-high gate signals for a three-phase inverter. A triangle counter sweeps up and then down over one switching period. Within each pair, the high-side signal is on while the counter sits at or above `period - duty`, so every pulse is centered on the top of the triangle. The low-side signal is the complement. Each rising edge is then delayed by a programmable dead time. A pulse shorter than a programmable minimum width is removed instead of being emitted as a sliver.

Period, duty and minimum width are sampled only at period boundaries. In double-update mode they are also sampled at the triangle peak, which allows asymmetric pulses. A sync strobe of programmable width marks each sampling point. Output-stage controls give:

- a per-pin enable;
- a per-pair crossover;
- a gate-drive chopping carrier, enabled separately for the high-side and low-side pins;
- a synchronous software halt;
- an active-low trip input that clears all six pins without waiting for a clock edge.

Top module: `cpwm3_gen`

## Requirements
- R1: While `rst_n` is low, `gate_o` and `sync_o` are all zero. After the first clock edge following reset release, `half_o` is 0 and `trip_lvl_o` follows the trip input (1 when idle).
- R2: The switching period lasts 2*P clock cycles, where P = `period_i` and values below 2 are taken as 2. `half_o` is 0 for the first P cycles and 1 for the last P cycles.
- R3: In `gate_o`, pair k uses bit 2k for its high side and bit 2k+1 for its low side (A = pair 0, B = 1, C = 2). With zero dead time and no deletion, the high side is on for 2*min(D,P) cycles per period, in one contiguous pulse centered on the half-period boundary. The low side is on for the remaining cycles.
- R4: Every rising edge of every pair signal is delayed by `dtime_i` cycles, so each pulse of length L lasts L - `dtime_i` cycles. The two pins of a pair are never high together.
- R5: If D < `minw_i`, the high side stays off for the whole period. If P - D < `minw_i`, the high side stays on for the whole period.
- R6: With `dbl_i` = 0, the duty values are sampled once per period, at its start. With `dbl_i` = 1, they are sampled again at the half-period boundary and govern the second half.
- R7: `sync_o` goes high for `syncw_i` cycles starting at each period start. With `dbl_i` = 1, it also does so starting at each half-period boundary.
- R8: An output whose bit in `en_i` is 0 stays low.
- R9: When bit k of `xover_i` is set, pair k's high-side signal drives its low-side pin, and its low-side signal drives its high-side pin.
- R10: The chopping carrier toggles every `chop_div_i`+1 cycles. `chop_hi_i` ANDs it into the even (high-side) pins, and `chop_lo_i` ANDs it into the odd (low-side) pins.
- R11: When `halt_i` is high at a clock edge, all pins are low from that edge on.
- R12: While `trip_n_i` is low, all pins are low with no clock edge needed. `trip_lvl_o` presents the trip input level registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 16 | Half-period length P in cycles |
| duty_i | input | 3x16 | Per-phase on-time per half period |
| minw_i | input | 16 | Minimum pulse width |
| dtime_i | input | 16 | Dead time in cycles |
| dbl_i | input | 1 | Double-update mode |
| syncw_i | input | 16 | Sync strobe width |
| en_i | input | 6 | Per-pin enable |
| xover_i | input | 3 | Per-pair crossover |
| chop_div_i | input | 8 | Chopping carrier half-period minus one |
| chop_hi_i | input | 1 | Chop the high-side pins |
| chop_lo_i | input | 1 | Chop the low-side pins |
| halt_i | input | 1 | Software shutdown |
| trip_n_i | input | 1 | Active-low asynchronous trip |
| gate_o | output | 6 | Gate drive pins |
| sync_o | output | 1 | Sync strobe |
| half_o | output | 1 | 0 in the first half, 1 in the second half |
| trip_lvl_o | output | 1 | Registered trip input level |

## Verification
The checker assumes that the control inputs change only between clock edges and that `halt_i` and `en_i` are already valid in the cycle before the edge that samples them. The enable and halt properties compare pins with the previous cycle's controls, so the bench drives every input on the falling edge.

The sync property assumes that a new strobe is never requested while the previous one is still running. The stimulus therefore keeps `syncw_i` well below the half-period length.

The trip property relies on `trip_n_i` being sampled at the same edges as `gate_o`. The bench changes the trip input only away from the rising edge.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // Half-period length actually used; below 2 the triangle cannot turn.
  function automatic cnt_t fit_period(cnt_t p);
    return (p < cnt_t'(2)) ? cnt_t'(2) : p;
  endfunction

  // Duty after clamping and narrow-pulse removal on either side.
  function automatic cnt_t eff_duty(cnt_t d, cnt_t p, cnt_t m);
    cnt_t dd;
    dd = (d > p) ? p : d;
    if (dd < m)          return '0;
    if ((p - dd) < m)    return p;
    return dd;
  endfunction

  // High side is on while the triangle is within the top band.
  function automatic logic hi_on(cnt_t t, cnt_t deff, cnt_t p);
    return t >= (p - deff);
  endfunction
endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase import cpwm_pkg::*; #(
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_t             period_i,
  input  cnt_t [NPH-1:0]   duty_i,
  input  cnt_t             minw_i,
  input  logic             dbl_i,
  input  cnt_t             syncw_i,
  output cnt_t             cnt_o,
  output cnt_t             plen_o,
  output cnt_t [NPH-1:0]   deff_o,
  output logic             half_o,
  output logic             sync_o,
  output logic             ev_start_o,
  output logic             ev_mid_o
);
  cnt_t cnt, plen, sync_cnt, p_new;
  cnt_t [NPH-1:0] deff;
  logic dir;

  assign p_new      = fit_period(period_i);
  assign ev_start_o = dir && (cnt == '0);
  assign ev_mid_o   = !dir && (cnt == plen - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir      <= 1'b1;
      plen     <= cnt_t'(2);
      deff     <= '0;
      sync_cnt <= '0;
    end else begin
      if (ev_start_o) begin
        dir  <= 1'b0;
        plen <= p_new;
        for (int i = 0; i < NPH; i++) deff[i] <= eff_duty(duty_i[i], p_new, minw_i);
      end else if (ev_mid_o) begin
        dir <= 1'b1;
        if (dbl_i)
          for (int i = 0; i < NPH; i++) deff[i] <= eff_duty(duty_i[i], plen, minw_i);
      end else if (dir) begin
        cnt <= cnt - cnt_t'(1);
      end else begin
        cnt <= cnt + cnt_t'(1);
      end
      if (ev_start_o || (ev_mid_o && dbl_i)) sync_cnt <= syncw_i;
      else if (sync_cnt != '0)               sync_cnt <= sync_cnt - cnt_t'(1);
    end
  end

  assign cnt_o  = cnt;
  assign plen_o = plen;
  assign deff_o = deff;
  assign half_o = dir;
  assign sync_o = (sync_cnt != '0);
endmodule

// File: rtl/cpwm_phase.sv
`timescale 1ns/1ps
module cpwm_phase import cpwm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  cnt_t       cnt_i,
  input  cnt_t       plen_i,
  input  cnt_t       deff_i,
  input  cnt_t       dt_i,
  output logic [1:0] pair_o
);
  logic [1:0] raw;
  assign raw[0] = hi_on(cnt_i, deff_i, plen_i);
  assign raw[1] = ~raw[0];

  for (genvar j = 0; j < 2; j++) begin : g_side
    cnt_t run;
    always_ff @(posedge clk) begin
      if (!rst_n || !raw[j]) begin
        run       <= '0;
        pair_o[j] <= 1'b0;
      end else begin
        pair_o[j] <= (run >= dt_i);
        if (run != '1) run <= run + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/cpwm_outstage.sv
`timescale 1ns/1ps
module cpwm_outstage #(
  parameter int NOUT   = 6,
  parameter int CHOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOUT-1:0]   d_i,
  input  logic [NOUT-1:0]   en_i,
  input  logic [NOUT/2-1:0] xover_i,
  input  logic [CHOP_W-1:0] chop_div_i,
  input  logic              chop_hi_i,
  input  logic              chop_lo_i,
  input  logic              halt_i,
  output logic [NOUT-1:0]   q_o
);
  localparam int NPAIR = NOUT / 2;
  logic [CHOP_W-1:0] cc;
  logic carr;
  logic [NOUT-1:0] nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc   <= '0;
      carr <= 1'b1;
    end else if (cc == chop_div_i) begin
      cc   <= '0;
      carr <= ~carr;
    end else begin
      cc <= cc + 1'b1;
    end
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic sel_h, sel_l;
    assign sel_h = xover_i[i] ? d_i[2*i+1] : d_i[2*i];
    assign sel_l = xover_i[i] ? d_i[2*i]   : d_i[2*i+1];
    assign nxt[2*i]   = sel_h & en_i[2*i]   & (~chop_hi_i | carr);
    assign nxt[2*i+1] = sel_l & en_i[2*i+1] & (~chop_lo_i | carr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || halt_i) q_o <= '0;
    else                  q_o <= nxt;
  end
endmodule

// File: rtl/cpwm3_gen.sv
`timescale 1ns/1ps
module cpwm3_gen import cpwm_pkg::*; #(
  parameter int NPH    = 3,
  parameter int CHOP_W = 8,
  localparam int NOUT  = 2 * NPH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W-1:0]            period_i,
  input  logic [NPH-1:0][CNT_W-1:0]   duty_i,
  input  logic [CNT_W-1:0]            minw_i,
  input  logic [CNT_W-1:0]            dtime_i,
  input  logic                        dbl_i,
  input  logic [CNT_W-1:0]            syncw_i,
  input  logic [NOUT-1:0]             en_i,
  input  logic [NPH-1:0]              xover_i,
  input  logic [CHOP_W-1:0]           chop_div_i,
  input  logic                        chop_hi_i,
  input  logic                        chop_lo_i,
  input  logic                        halt_i,
  input  logic                        trip_n_i,
  output logic [NOUT-1:0]             gate_o,
  output logic                        sync_o,
  output logic                        half_o,
  output logic                        trip_lvl_o
);
  cnt_t cnt, plen;
  cnt_t [NPH-1:0] deff;
  logic ev_start, ev_mid;
  logic [NOUT-1:0] shaped, q;

  cpwm_timebase #(.NPH(NPH)) tb_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .minw_i(minw_i), .dbl_i(dbl_i), .syncw_i(syncw_i), .cnt_o(cnt),
    .plen_o(plen), .deff_o(deff), .half_o(half_o), .sync_o(sync_o),
    .ev_start_o(ev_start), .ev_mid_o(ev_mid)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    cpwm_phase ph_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .plen_i(plen),
      .deff_i(deff[k]), .dt_i(dtime_i), .pair_o(shaped[2*k+1:2*k])
    );
  end

  cpwm_outstage #(.NOUT(NOUT), .CHOP_W(CHOP_W)) os_i (
    .clk(clk), .rst_n(rst_n), .d_i(shaped), .en_i(en_i), .xover_i(xover_i),
    .chop_div_i(chop_div_i), .chop_hi_i(chop_hi_i), .chop_lo_i(chop_lo_i),
    .halt_i(halt_i), .q_o(q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trip_lvl_o <= 1'b1;
    else        trip_lvl_o <= trip_n_i;
  end

  // Unclocked kill path from the trip input to the pins.
  assign gate_o = q & {NOUT{trip_n_i}};
endmodule

// File: rtl/cpwm3_gen_chk.sv
`timescale 1ns/1ps
module cpwm3_gen_chk #(
  parameter int NOUT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NOUT-1:0] gate_o,
  input logic [NOUT-1:0] en_i,
  input logic            trip_n_i,
  input logic            halt_i,
  input logic            sync_o,
  input logic            half_o,
  input logic            ev_start
);
  // R12: pins dead while the trip is held
  assert_trip_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n_i |-> (gate_o == '0));

  // R11: halt sampled at an edge clears every pin
  assert_halt_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_i) |-> (gate_o == '0));

  // R8: a disabled pin stays low
  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~en_i)) & gate_o) == '0);

  // R7: strobe starts only where a half begins
  assert_sync_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (half_o != $past(half_o)));

  // R2: a period start opens the first half
  assert_start_first_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !half_o);

  // R4: the pins of one pair never overlap
  for (genvar i = 0; i < NOUT/2; i++) begin : g_pair
    assert_pair_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[2*i] && gate_o[2*i+1]));
  end
endmodule

bind cpwm3_gen cpwm3_gen_chk #(.NOUT(NOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .en_i(en_i), .trip_n_i(trip_n_i),
  .halt_i(halt_i), .sync_o(sync_o), .half_o(half_o), .ev_start(ev_start)
);

// File: tb/cpwm3_gen_tb_top.sv
`timescale 1ns/1ps
module cpwm3_gen_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [15:0] period_i, minw_i, dtime_i, syncw_i;
  logic [2:0][15:0] duty_i;
  logic dbl_i, chop_hi_i, chop_lo_i, halt_i, trip_n_i;
  logic [5:0] en_i, gate_o;
  logic [2:0] xover_i;
  logic [7:0] chop_div_i;
  logic sync_o, half_o, trip_lvl_o;

  cpwm3_gen dut_i (.*);

  int nchk = 0, nerr = 0;
  int cg[6];
  int ch, cs, ov;

  // Fields: P, D, MIN, DT, expected AH count, expected AL count (4 periods)
  localparam logic [95:0] VEC [8] = '{
    {16'd8,  16'd4,  16'd0, 16'd0, 16'd32, 16'd32},
    {16'd8,  16'd2,  16'd0, 16'd0, 16'd16, 16'd48},
    {16'd10, 16'd7,  16'd0, 16'd2, 16'd48, 16'd16},
    {16'd8,  16'd1,  16'd2, 16'd0, 16'd0,  16'd64},
    {16'd8,  16'd7,  16'd2, 16'd0, 16'd64, 16'd0 },
    {16'd8,  16'd12, 16'd0, 16'd0, 16'd64, 16'd0 },
    {16'd6,  16'd3,  16'd3, 16'd1, 16'd20, 16'd20},
    {16'd1,  16'd1,  16'd0, 16'd0, 16'd8,  16'd8 }
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int settle, input int win, input bit alt, input int da, input int db);
    for (int k = 0; k < 6; k++) cg[k] = 0;
    ch = 0; cs = 0; ov = 0;
    for (int c = 0; c < settle + win; c++) begin
      @(negedge clk);
      if (c >= settle) begin
        for (int k = 0; k < 6; k++) cg[k] += int'(gate_o[k]);
        ch += int'(half_o);
        cs += int'(sync_o);
        for (int p = 0; p < 3; p++) if (gate_o[2*p] && gate_o[2*p+1]) ov++;
      end
      if (alt) duty_i[0] = half_o ? 16'(db) : 16'(da);
    end
  endtask

  task automatic set_duty(input int d);
    for (int i = 0; i < 3; i++) duty_i[i] = 16'(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog all requirements actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 0; period_i = 16'd8; minw_i = 0; dtime_i = 0; syncw_i = 0;
    set_duty(0); dbl_i = 0; chop_hi_i = 0; chop_lo_i = 0; halt_i = 0;
    trip_n_i = 1; en_i = '1; xover_i = 0; chop_div_i = 0;
    repeat (4) @(negedge clk);
    chk("R1 gate in reset", int'(gate_o), 0);
    chk("R1 sync in reset", int'(sync_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 half after reset", int'(half_o), 0);
    chk("R1 trip level idle", int'(trip_lvl_o), 1);

    // Table walk: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      int p, win;
      p = int'(VEC[v][95:80]);
      if (p < 2) p = 2;
      win = 8 * p;
      period_i = VEC[v][95:80];
      set_duty(int'(VEC[v][79:64]));
      minw_i  = VEC[v][63:48];
      dtime_i = VEC[v][47:32];
      run(60, win, 0, 0, 0);
      chk($sformatf("R3 R5 vec%0d AH", v), cg[0], int'(VEC[v][31:16]));
      chk($sformatf("R3 R4 vec%0d AL", v), cg[1], int'(VEC[v][15:0]));
      chk($sformatf("R3 vec%0d CH", v),    cg[4], int'(VEC[v][31:16]));
      chk($sformatf("R2 vec%0d half", v),  ch, 4 * p);
      chk($sformatf("R4 vec%0d overlap", v), ov, 0);
    end
    period_i = 16'd8; minw_i = 0; dtime_i = 0;

    // R6: duty offered per half; single samples only at start
    run(60, 64, 1, 2, 6);
    chk("R6 single update AH", cg[0], 48);
    dbl_i = 1;
    run(60, 64, 1, 2, 6);
    chk("R6 double update AH", cg[0], 32);
    dbl_i = 0;

    // R7: sync strobe
    set_duty(4); syncw_i = 16'd3;
    run(60, 64, 0, 0, 0);
    chk("R7 sync single", cs, 12);
    dbl_i = 1;
    run(60, 64, 0, 0, 0);
    chk("R7 sync double", cs, 24);
    dbl_i = 0; syncw_i = 0;

    // R8: enable
    en_i = 6'b111110;
    run(60, 64, 0, 0, 0);
    chk("R8 disabled AH", cg[0], 0);
    chk("R8 enabled AL", cg[1], 32);
    en_i = '1;

    // R9: crossover on pair A
    set_duty(2); xover_i = 3'b001;
    run(60, 64, 0, 0, 0);
    chk("R9 crossed AH", cg[0], 48);
    chk("R9 crossed AL", cg[1], 16);
    chk("R9 uncrossed BH", cg[2], 16);
    xover_i = 0;

    // R10: chopping, carrier period 8
    set_duty(8); chop_div_i = 8'd3; chop_hi_i = 1;
    run(60, 64, 0, 0, 0);
    chk("R10 chop hi AH", cg[0], 32);
    chk("R10 chop hi BH", cg[2], 32);
    chop_hi_i = 0; chop_lo_i = 1; set_duty(0);
    run(60, 64, 0, 0, 0);
    chk("R10 chop lo AL", cg[1], 32);
    chk("R10 chop lo AH", cg[0], 0);
    chop_lo_i = 0; set_duty(8);

    // R11: software halt
    run(60, 0, 0, 0, 0);
    chk("R11 before halt AH", int'(gate_o[0]), 1);
    halt_i = 1;
    @(negedge clk);
    chk("R11 halted", int'(gate_o), 0);
    halt_i = 0;
    @(negedge clk);
    chk("R11 released AH", int'(gate_o[0]), 1);

    // R12: trip
    trip_n_i = 0;
    #1;
    chk("R12 trip immediate", int'(gate_o), 0);
    @(negedge clk);
    chk("R12 trip level low", int'(trip_lvl_o), 0);
    trip_n_i = 1;
    @(negedge clk);
    chk("R12 trip level back", int'(trip_lvl_o), 1);
    chk("R12 pins back AH", int'(gate_o[0]), 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule